// File: doc/BRIEF.md
# SPI Receive Status and Overflow Logic

This block sits between the serial shifter of an SPI receiver and a CPU bus. It holds the last accepted receive byte and two status flags: receiver full and overflow. Each time the shifter finishes a byte it raises a strobe. The block then either loads the byte and sets receiver full, or drops the byte and sets overflow. It drops the byte when an earlier byte is still unread or an overflow is still pending.

Software clears each flag with a two-step sequence. First it reads the status register, which arms every flag it sees set. Then it reads the data register, which clears the armed flags. A flag set after the status read is not cleared by that data read. So one status/data pair can clear receiver full and leave overflow pending. A second status read then shows the overflow. The receive interrupt follows receiver full. The error interrupt follows overflow, gated by an enable bit.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, both flags and both arming bits are 0, the data register reads 0x00, the status register reads 0x00 and both interrupt requests are low.
- R2: A byte strobe with no flag set loads the byte into the data register and sets receiver full. Receiver full is status bit 7, so the status reads 0x80. All of this is visible the cycle after the strobe.
- R3: A byte strobe while receiver full or overflow is set sets overflow (status bit 6) and discards the byte. The data register keeps its earlier value.
- R4: Receiver full clears only on a data read that follows a status read which saw it set. A data read with no such status read leaves it set.
- R5: Overflow clears only on a data read that follows a status read which saw it set. That data read returns the byte retained before the overflow.
- R6: While overflow is set, byte strobes never set receiver full and the receive interrupt stays low. After overflow clears, the next byte sets receiver full again.
- R7: The error interrupt request is high exactly when overflow is set and the error-interrupt enable is high. With the enable low, overflow raises no interrupt.
- R8: If the last status read armed only receiver full, a data read clears receiver full and leaves overflow set. The status then reads 0x40.
- R9: If a byte strobe and a clearing data read occur in the same cycle, the clear is applied first. The byte is then loaded and sets receiver full, and overflow stays clear.
- R10: The receive interrupt request equals the receiver-full flag at all times.
- R11: Each status read replaces both arming bits with the flag values it sees. A data read consumes the arming bits, so a second data read with no status read in between clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_vld_i | input | 1 | One-cycle strobe: a received byte is complete |
| rx_byte_i | input | DATA_W | Received byte, valid with the strobe |
| stat_rd_i | input | 1 | CPU read of the status register |
| data_rd_i | input | 1 | CPU read of the data register |
| err_ie_i | input | 1 | Error-interrupt enable |
| status_o | output | STAT_W | Status register: bit 7 receiver full, bit 6 overflow, other bits 0 |
| data_o | output | DATA_W | Data register contents |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The bench replays the lost-byte sequence. In it, a status read arms only receiver full, overflow strikes, and a data read then leaves overflow pending. A design that cleared both flags on any data read would lose the overflow silently. A design that loaded the dropped byte would return the wrong data on the final read. The bench also issues a data read with no status read, or after a stale status read. A design without arming, or one that did not consume the arming bits, would clear receiver full too early. Finally, a byte lands in the same cycle as a clearing data read. A design that evaluated the byte before the clear would report a false overflow.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  typedef struct packed {
    logic full;
    logic ovr;
  } rx_flags_t;

endpackage

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
  import spi_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      byte_vld_i,
  input  logic      stat_rd_i,
  input  logic      data_rd_i,
  output rx_flags_t flags_o,
  output logic      load_o
);

  rx_flags_t flags_q, flags_d;
  rx_flags_t arm_q;
  logic      clr_full, clr_ovr;
  logic      full_mid, ovr_mid;
  logic      blocked;

  // Clearing reads are evaluated before the incoming byte.
  always_comb begin
    clr_full = data_rd_i & arm_q.full;
    clr_ovr  = data_rd_i & arm_q.ovr;
    full_mid = flags_q.full & ~clr_full;
    ovr_mid  = flags_q.ovr  & ~clr_ovr;
    blocked  = full_mid | ovr_mid;
    load_o   = byte_vld_i & ~blocked;
    flags_d.full = full_mid | load_o;
    flags_d.ovr  = ovr_mid  | (byte_vld_i & blocked);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      flags_q <= flags_d;
      if (stat_rd_i)      arm_q <= flags_q;
      else if (data_rd_i) arm_q <= '0;
    end
  end

  assign flags_o = flags_q;

  // R4: receiver full only falls after an armed data read
  a_r4_full_clear_armed: assert property (@(posedge clk) disable iff (rst)
    $fell(flags_q.full) |-> $past(data_rd_i && arm_q.full));

  // R5: overflow only falls after an armed data read
  a_r5_ovr_clear_armed: assert property (@(posedge clk) disable iff (rst)
    $fell(flags_q.ovr) |-> $past(data_rd_i && arm_q.ovr));

  // R6: with overflow held, receiver full cannot rise
  a_r6_no_full_while_ovr: assert property (@(posedge clk) disable iff (rst)
    (flags_q.ovr && !flags_q.full && !data_rd_i) |=> !flags_q.full);

endmodule

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst)         data_q <= '0;
    else if (load_i) data_q <= byte_i;
  end

  assign data_o = data_q;

endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import spi_rx_pkg::*;
(
  input  rx_flags_t flags_i,
  input  logic      err_ie_i,
  output logic      rx_irq_o,
  output logic      err_irq_o
);

  always_comb begin
    rx_irq_o  = flags_i.full;
    err_irq_o = flags_i.ovr & err_ie_i;
  end

endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STAT_W   = 8,
  parameter int FULL_POS = 7,
  parameter int OVR_POS  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_byte_vld_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              err_ie_i,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);

  rx_flags_t flags;
  logic      load;

  rx_flag_ctrl u_flags (
    .clk        (clk),
    .rst        (rst),
    .byte_vld_i (rx_byte_vld_i),
    .stat_rd_i  (stat_rd_i),
    .data_rd_i  (data_rd_i),
    .flags_o    (flags),
    .load_o     (load)
  );

  rx_data_hold #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .byte_i (rx_byte_i),
    .data_o (data_o)
  );

  rx_irq_gen u_irq (
    .flags_i   (flags),
    .err_ie_i  (err_ie_i),
    .rx_irq_o  (rx_irq_o),
    .err_irq_o (err_irq_o)
  );

  // Status word: two flag bits at fixed positions, the rest zero.
  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == FULL_POS)     begin : g_full assign status_o[i] = flags.full; end
    else if (i == OVR_POS) begin : g_ovr  assign status_o[i] = flags.ovr;  end
    else                   begin : g_zero assign status_o[i] = 1'b0;       end
  end

  // R2: an unblocked byte is loaded and marks the register full
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (rx_byte_vld_i && !status_o[FULL_POS] && !status_o[OVR_POS])
      |=> (rx_irq_o && data_o == $past(rx_byte_i)));

  // R3: a byte arriving while blocked sets overflow and leaves data alone
  a_r3_drop_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (rx_byte_vld_i && !data_rd_i && (status_o[FULL_POS] || status_o[OVR_POS]))
      |=> (status_o[OVR_POS] && $stable(data_o)));

  // R7: with the enable low there is never an error request
  a_r7_err_gated: assert property (@(posedge clk) disable iff (rst)
    !err_ie_i |-> !err_irq_o);

endmodule

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       vld, srd, drd, ie;
  logic [7:0] bin;
  logic [7:0] status, data;
  logic       rx_irq, err_irq;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] seen;

  always #2.5 clk = ~clk;

  spi_rx_status u_dut (
    .clk           (clk),
    .rst           (rst),
    .rx_byte_vld_i (vld),
    .rx_byte_i     (bin),
    .stat_rd_i     (srd),
    .data_rd_i     (drd),
    .err_ie_i      (ie),
    .status_o      (status),
    .data_o        (data),
    .rx_irq_o      (rx_irq),
    .err_irq_o     (err_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, let one posedge pass, sample at next negedge.
  task automatic cyc(input logic v, input logic [7:0] b, input logic s, input logic d);
    vld = v; bin = b; srd = s; drd = d;
    seen = status;
    @(negedge clk);
    vld = 0; srd = 0; drd = 0;
  endtask

  task automatic rx(input logic [7:0] b);  cyc(1, b, 0, 0); endtask
  task automatic rd_stat();                cyc(0, 0, 1, 0); endtask
  task automatic rd_data();                cyc(0, 0, 0, 1); endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 data", data, 8'h00);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 err_irq", err_irq, 0);
  endtask

  task automatic t_load_and_clear();
    rx(8'hA5);
    chk("R2 status", status, 8'h80);
    chk("R2 data", data, 8'hA5);
    chk("R10 rx_irq", rx_irq, 1);
    rd_data();
    chk("R4 unarmed read keeps full", status, 8'h80);
    rd_stat();
    chk("R4 status seen", seen, 8'h80);
    rd_data();
    chk("R4 armed read clears", status, 8'h00);
    chk("R10 rx_irq low", rx_irq, 0);
  endtask

  task automatic t_lost_byte();
    ie = 0;
    rx(8'h11);
    rd_stat();
    rx(8'h22);
    chk("R3 status", status, 8'hC0);
    chk("R3 data kept", data, 8'h11);
    chk("R7 no err irq when disabled", err_irq, 0);
    rd_data();
    chk("R8 partial clear", status, 8'h40);
    chk("R6 rx_irq low", rx_irq, 0);
    rx(8'h33);
    chk("R6 full blocked", status, 8'h40);
    chk("R3 data kept 2", data, 8'h11);
    ie = 1;
    @(negedge clk);
    chk("R7 err irq enabled", err_irq, 1);
    rd_stat();
    chk("R8 second status read shows ovr", seen, 8'h40);
    chk("R5 read returns retained", data, 8'h11);
    rd_data();
    chk("R5 ovr cleared", status, 8'h00);
    chk("R7 err irq drops", err_irq, 0);
    rx(8'h44);
    chk("R6 full resumes", status, 8'h80);
    chk("R6 data", data, 8'h44);
    ie = 0;
  endtask

  task automatic t_same_cycle();
    rd_stat();
    cyc(1, 8'h55, 0, 1);
    chk("R9 status", status, 8'h80);
    chk("R9 data", data, 8'h55);
    rd_stat();
    rd_data();
    chk("R9 cleanup", status, 8'h00);
  endtask

  task automatic t_arming();
    rd_stat();
    rx(8'h66);
    rd_data();
    chk("R11 stale status read arms nothing", status, 8'h80);
    rd_stat();
    rd_data();
    chk("R11 fresh arm clears", status, 8'h00);
    rx(8'h77);
    rd_data();
    chk("R11 arm consumed", status, 8'h80);
    chk("R11 data", data, 8'h77);
  endtask

  initial begin
    vld = 0; srd = 0; drd = 0; ie = 0; bin = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load_and_clear();
    t_lost_byte();
    t_same_cycle();
    t_arming();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule